// File: doc/BRIEF.md
# Command and Response Byte FIFO with Status Word

This block is the data path between a host and the command engine of a security module. The host talks to it through a byte-wide register port. It first signals command-ready, then streams the command bytes into a data port, then issues go. The block passes the buffered command to a back-end through a small handshake. The back-end writes its response into the same buffer and reports the response length. The host then reads the response bytes back out through the same data port.

A 32-bit status word reports progress. It holds a flag byte and a 16-bit burst count. While a command is being written, the burst count is the free space left in the buffer. While a response is being read, it is the number of response bytes still unread. The block reads a big-endian length field from the command header and drops the expect flag once that many bytes have arrived. A CRC-16 runs over every command byte, and software can turn on a register that makes the CRC readable. The interrupt registers are fixed at zero. Any other address reads all ones.

Top module: `cmdrsp_fifo`

## Requirements
- R1: After reset, status flags (word bits 7:0) read 0x00, the burst count (bits 23:8) reads DEPTH (default 128, at least 128), and `be_req` is low. A go write (bit 5 at offset 0x00) in this phase is ignored.
- R2: The status word is readable little-endian at offsets 0x00–0x03. Offset 0x03 (bits 31:24) always reads 0x00, and a write to offset 0x03 leaves the whole word unchanged. Two byte reads at offsets 0x01/0x02 give the burst count.
- R3: Writing a byte with bit 6 set to offset 0x00 enters the ready phase from any phase. Flags then read exactly 0x40, the burst count reads DEPTH, and the byte count and checksum clear.
- R4: Each byte written to the data port (offset 0x04) in the ready or receiving phase is stored and lowers the burst count by one. The write is ignored when the buffer is full, and also in the idle, executing and response phases.
- R5: While receiving, the flags read 0x88 (valid bit 7 plus expect bit 3) while fewer than 6 bytes, or fewer than the big-endian 32-bit length in command bytes 2..5, have been written. Otherwise they read 0x80.
- R6: A go write (bit 5 at offset 0x00, bit 6 clear) in the ready or receiving phase raises `be_req`, sets flags 0x80 and burst 0, and sets `be_cmd_len` to the number of bytes written. `be_cmd_byte` shows the buffered byte at `be_cmd_idx`.
- R7: While `be_req` is high, `be_rsp_we` writes a byte into the buffer. `be_rsp_done` drops `be_req` and makes the flags read 0x90 (valid plus data-available bit 4). The burst count then equals `be_rsp_len`, capped at DEPTH.
- R8: Reads of offset 0x04 return the response bytes in order, and each read lowers the burst count by one. After the last byte, the flags read 0x80 and the burst is 0. Further reads return 0x00 and change nothing.
- R9: Offset 0x08 bit 0 is the checksum enable. Only bit 0 is stored, and offsets 0x09–0x0B read 0x00.
- R10: Offsets 0x0C (low byte) and 0x0D (high byte) read a CRC-16 over all data bytes written since command-ready. The CRC uses reflected polynomial 0x8408, initial value 0 and no final XOR. These offsets read 0 while the enable is clear.
- R11: Offsets 0x10–0x17 (interrupt capability and enable) read 0x00, even after 0xFF is written to them.
- R12: Every other offset (for example 0x05–0x07, 0x0E, 0x20, 0xFF) reads 0xFF, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register byte write strobe |
| reg_rd | input | 1 | Register byte read strobe (pops the data port) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| be_req | output | 1 | Command buffered, back-end owns the buffer |
| be_cmd_len | output | 16 | Number of command bytes |
| be_cmd_idx | input | IDXW | Back-end command read index |
| be_cmd_byte | output | 8 | Command byte at `be_cmd_idx` |
| be_rsp_we | input | 1 | Back-end response byte write |
| be_rsp_idx | input | IDXW | Response byte index |
| be_rsp_byte | input | 8 | Response byte |
| be_rsp_done | input | 1 | Response complete |
| be_rsp_len | input | 16 | Response length in bytes |

## Verification
The hardest states to reach are the edges of the buffer. One is a completely full command buffer whose header declares an even larger length, so expect stays set while the burst count sits at zero. Another is a back-end that reports more response bytes than the buffer can hold. Directed sequences fill all DEPTH bytes with an all-ones length field, write past the end, and report a 300-byte response. Seeded random transactions separately pick the declared and written lengths, so that go is issued both before and after the expect flag drops.

// File: rtl/cmdrsp_pkg.sv
package cmdrsp_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_READY = 3'd1,
        PH_RECV  = 3'd2,
        PH_EXEC  = 3'd3,
        PH_RESP  = 3'd4
    } phase_e;

    // register byte offsets
    localparam logic [7:0] OFS_STS0    = 8'h00;
    localparam logic [7:0] OFS_STS1    = 8'h01;
    localparam logic [7:0] OFS_STS2    = 8'h02;
    localparam logic [7:0] OFS_STS3    = 8'h03;
    localparam logic [7:0] OFS_DATA    = 8'h04;
    localparam logic [7:0] OFS_CKEN0   = 8'h08;
    localparam logic [7:0] OFS_CKEN_HI = 8'h0B;
    localparam logic [7:0] OFS_CKLO    = 8'h0C;
    localparam logic [7:0] OFS_CKHI    = 8'h0D;
    localparam logic [7:0] OFS_IRQ_LO  = 8'h10;
    localparam logic [7:0] OFS_IRQ_HI  = 8'h17;

    // flag bit positions in status byte 0
    localparam int FB_VALID  = 7;
    localparam int FB_CMDRDY = 6;
    localparam int FB_GO     = 5;
    localparam int FB_AVAIL  = 4;
    localparam int FB_EXPECT = 3;

    // big-endian length field position inside the command header
    localparam int HDR_LEN_FIRST = 2;
    localparam int HDR_LEN_LAST  = 5;

endpackage

// File: rtl/cmdrsp_crc16.sv
module cmdrsp_crc16 #(
    parameter logic [15:0] POLY_REFL = 16'h8408
) (
    input  logic [15:0] crc_i,
    input  logic [7:0]  data_i,
    output logic [15:0] crc_o
);
    always_comb begin
        logic [15:0] acc;
        acc = crc_i ^ {8'h00, data_i};
        for (int b = 0; b < 8; b++) begin
            acc = acc[0] ? ((acc >> 1) ^ POLY_REFL) : (acc >> 1);
        end
        crc_o = acc;
    end
endmodule

// File: rtl/cmdrsp_buf.sv
module cmdrsp_buf #(
    parameter int DEPTH = 128,
    parameter int IDXW  = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            we_i,
    input  logic [IDXW-1:0] widx_i,
    input  logic [7:0]      wbyte_i,
    input  logic [IDXW-1:0] ridx_a_i,
    output logic [7:0]      rbyte_a_o,
    input  logic [IDXW-1:0] ridx_b_i,
    output logic [7:0]      rbyte_b_o
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[widx_i] <= wbyte_i;
        end
    end

    assign rbyte_a_o = mem_q[ridx_a_i];
    assign rbyte_b_o = mem_q[ridx_b_i];
endmodule

// File: rtl/cmdrsp_status.sv
module cmdrsp_status
    import cmdrsp_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  phase_e        phase_i,
    input  logic [CW-1:0] wcnt_i,
    input  logic [CW-1:0] rcnt_i,
    input  logic [CW-1:0] rsp_len_i,
    input  logic [31:0]   cmd_len_i,
    output logic [31:0]   sts_o
);
    localparam logic [15:0] DEPTH16 = 16'(DEPTH);

    logic [7:0]  flags;
    logic [15:0] burst;
    logic        want_more;

    always_comb begin
        want_more = (32'(wcnt_i) < 32'(HDR_LEN_LAST + 1)) || (32'(wcnt_i) < cmd_len_i);
        flags     = 8'h00;
        burst     = 16'h0000;
        unique case (phase_i)
            PH_IDLE: begin
                burst = DEPTH16;
            end
            PH_READY: begin
                flags[FB_CMDRDY] = 1'b1;
                burst            = DEPTH16;
            end
            PH_RECV: begin
                flags[FB_VALID]  = 1'b1;
                flags[FB_EXPECT] = want_more;
                burst            = DEPTH16 - 16'(wcnt_i);
            end
            PH_EXEC: begin
                flags[FB_VALID] = 1'b1;
            end
            PH_RESP: begin
                flags[FB_VALID] = 1'b1;
                flags[FB_AVAIL] = (rcnt_i < rsp_len_i);
                burst           = 16'(rsp_len_i) - 16'(rcnt_i);
            end
            default: ;
        endcase
        sts_o = {8'h00, burst, flags};
    end
endmodule

// File: rtl/cmdrsp_fifo.sv
module cmdrsp_fifo
    import cmdrsp_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int IDXW  = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [7:0]      reg_addr,
    input  logic [7:0]      reg_wdata,
    output logic [7:0]      reg_rdata,
    output logic            be_req,
    output logic [15:0]     be_cmd_len,
    input  logic [IDXW-1:0] be_cmd_idx,
    output logic [7:0]      be_cmd_byte,
    input  logic            be_rsp_we,
    input  logic [IDXW-1:0] be_rsp_idx,
    input  logic [7:0]      be_rsp_byte,
    input  logic            be_rsp_done,
    input  logic [15:0]     be_rsp_len
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] wcnt;
        logic [CW-1:0] rcnt;
        logic [CW-1:0] rsp_len;
        logic [31:0]   cmd_len;
        logic [15:0]   crc;
        logic          ck_en;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic            buf_we;
    logic [IDXW-1:0] buf_widx;
    logic [7:0]      buf_wbyte;
    logic [7:0]      rsp_byte;
    logic [15:0]     crc_nxt;
    logic [31:0]     sts_w;
    logic            accepting;
    logic            has_rsp;

    cmdrsp_crc16 u_crc (
        .crc_i  (ctl_q.crc),
        .data_i (reg_wdata),
        .crc_o  (crc_nxt)
    );

    cmdrsp_buf #(.DEPTH(DEPTH), .IDXW(IDXW)) u_buf (
        .clk       (clk),
        .we_i      (buf_we),
        .widx_i    (buf_widx),
        .wbyte_i   (buf_wbyte),
        .ridx_a_i  (ctl_q.rcnt[IDXW-1:0]),
        .rbyte_a_o (rsp_byte),
        .ridx_b_i  (be_cmd_idx),
        .rbyte_b_o (be_cmd_byte)
    );

    cmdrsp_status #(.DEPTH(DEPTH), .CW(CW)) u_sts (
        .phase_i   (ctl_q.phase),
        .wcnt_i    (ctl_q.wcnt),
        .rcnt_i    (ctl_q.rcnt),
        .rsp_len_i (ctl_q.rsp_len),
        .cmd_len_i (ctl_q.cmd_len),
        .sts_o     (sts_w)
    );

    assign accepting = (ctl_q.phase == PH_READY) || (ctl_q.phase == PH_RECV);
    assign has_rsp   = (ctl_q.phase == PH_RESP) && (ctl_q.rcnt < ctl_q.rsp_len);

    always_comb begin
        ctl_d     = ctl_q;
        buf_we    = 1'b0;
        buf_widx  = '0;
        buf_wbyte = '0;

        if (ctl_q.phase == PH_EXEC) begin
            if (be_rsp_we) begin
                buf_we    = 1'b1;
                buf_widx  = be_rsp_idx;
                buf_wbyte = be_rsp_byte;
            end
            if (be_rsp_done) begin
                ctl_d.phase   = PH_RESP;
                ctl_d.rcnt    = '0;
                ctl_d.rsp_len = (be_rsp_len > 16'(DEPTH)) ? CW'(DEPTH) : CW'(be_rsp_len);
            end
        end

        if (reg_rd && (reg_addr == OFS_DATA) && has_rsp) begin
            ctl_d.rcnt = ctl_q.rcnt + CW'(1);
        end

        if (reg_wr) begin
            unique case (reg_addr)
                OFS_STS0: begin
                    if (reg_wdata[FB_CMDRDY]) begin
                        ctl_d.phase   = PH_READY;
                        ctl_d.wcnt    = '0;
                        ctl_d.rcnt    = '0;
                        ctl_d.rsp_len = '0;
                        ctl_d.cmd_len = '0;
                        ctl_d.crc     = '0;
                    end else if (reg_wdata[FB_GO] && accepting) begin
                        ctl_d.phase = PH_EXEC;
                    end
                end
                OFS_DATA: begin
                    if (accepting && (ctl_q.wcnt < CW'(DEPTH))) begin
                        buf_we      = 1'b1;
                        buf_widx    = ctl_q.wcnt[IDXW-1:0];
                        buf_wbyte   = reg_wdata;
                        ctl_d.wcnt  = ctl_q.wcnt + CW'(1);
                        ctl_d.phase = PH_RECV;
                        ctl_d.crc   = crc_nxt;
                        if ((ctl_q.wcnt >= CW'(HDR_LEN_FIRST)) && (ctl_q.wcnt <= CW'(HDR_LEN_LAST))) begin
                            ctl_d.cmd_len = {ctl_q.cmd_len[23:0], reg_wdata};
                        end
                    end
                end
                OFS_CKEN0: begin
                    ctl_d.ck_en = reg_wdata[0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        reg_rdata = 8'hFF;
        if (reg_addr inside {[OFS_IRQ_LO:OFS_IRQ_HI]}) begin
            reg_rdata = 8'h00;
        end else if (reg_addr inside {[OFS_CKEN0 + 8'd1:OFS_CKEN_HI]}) begin
            reg_rdata = 8'h00;
        end else begin
            unique case (reg_addr)
                OFS_STS0:  reg_rdata = sts_w[7:0];
                OFS_STS1:  reg_rdata = sts_w[15:8];
                OFS_STS2:  reg_rdata = sts_w[23:16];
                OFS_STS3:  reg_rdata = sts_w[31:24];
                OFS_DATA:  reg_rdata = has_rsp ? rsp_byte : 8'h00;
                OFS_CKEN0: reg_rdata = {7'b0, ctl_q.ck_en};
                OFS_CKLO:  reg_rdata = ctl_q.ck_en ? ctl_q.crc[7:0] : 8'h00;
                OFS_CKHI:  reg_rdata = ctl_q.ck_en ? ctl_q.crc[15:8] : 8'h00;
                default:   ;
            endcase
        end
    end

    assign be_req     = (ctl_q.phase == PH_EXEC);
    assign be_cmd_len = 16'(ctl_q.wcnt);
endmodule

// File: rtl/cmdrsp_fifo_chk.sv
module cmdrsp_fifo_chk #(
    parameter int DEPTH = 128
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic [7:0]  reg_addr,
    input logic        wr_cmdrdy,
    input logic        be_req,
    input logic        be_rsp_done,
    input logic [23:0] sts_word
);
    AST_CMDRDY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) (reg_wr && reg_addr == 8'h00 && wr_cmdrdy) |=> (sts_word[7:0] == 8'h40 && sts_word[23:8] == 16'(DEPTH))); // R3
    AST_PUSH_DECR: assert property (@(posedge clk) disable iff (!rst_n) (reg_wr && reg_addr == 8'h04 && !be_req && sts_word[23:8] != 16'd0 && (sts_word[7:0] == 8'h40 || (sts_word[7] && !sts_word[4]))) |=> (sts_word[23:8] == $past(sts_word[23:8]) - 16'd1)); // R4
    AST_EXPECT_VALID: assert property (@(posedge clk) disable iff (!rst_n) sts_word[3] |-> (sts_word[7] && !sts_word[4])); // R5
    AST_REQ_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) be_req |-> (sts_word[7:0] == 8'h80 && sts_word[23:8] == 16'd0)); // R6
    AST_DONE_DROP: assert property (@(posedge clk) disable iff (!rst_n) (be_req && be_rsp_done && !reg_wr) |=> (!be_req && sts_word[7])); // R7
    AST_POP_DECR: assert property (@(posedge clk) disable iff (!rst_n) (reg_rd && !reg_wr && reg_addr == 8'h04 && sts_word[4]) |=> (sts_word[23:8] == $past(sts_word[23:8]) - 16'd1)); // R8
endmodule

bind cmdrsp_fifo cmdrsp_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .wr_cmdrdy   (reg_wdata[6]),
    .be_req      (be_req),
    .be_rsp_done (be_rsp_done),
    .sts_word    (sts_w[23:0])
);

// File: tb/cmdrsp_fifo_tb_top.sv
module cmdrsp_fifo_tb_top;
    localparam int DEPTH = 128;
    localparam int IDXW  = $clog2(DEPTH);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr = 1'b0;
    logic            reg_rd = 1'b0;
    logic [7:0]      reg_addr = 8'h00;
    logic [7:0]      reg_wdata = 8'h00;
    logic [7:0]      reg_rdata;
    logic            be_req;
    logic [15:0]     be_cmd_len;
    logic [IDXW-1:0] be_cmd_idx = '0;
    logic [7:0]      be_cmd_byte;
    logic            be_rsp_we = 1'b0;
    logic [IDXW-1:0] be_rsp_idx = '0;
    logic [7:0]      be_rsp_byte = 8'h00;
    logic            be_rsp_done = 1'b0;
    logic [15:0]     be_rsp_len = 16'h0000;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    logic [7:0] cmd [DEPTH];
    logic [7:0] rsp [DEPTH];

    always #4 clk = ~clk;

    cmdrsp_fifo #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .be_req(be_req), .be_cmd_len(be_cmd_len), .be_cmd_idx(be_cmd_idx),
        .be_cmd_byte(be_cmd_byte), .be_rsp_we(be_rsp_we), .be_rsp_idx(be_rsp_idx),
        .be_rsp_byte(be_rsp_byte), .be_rsp_done(be_rsp_done), .be_rsp_len(be_rsp_len)
    );

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c ^ {8'h00, b};
        for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
        return r;
    endfunction

    function automatic logic [7:0] recv_flags(input int written, input int declared);
        return ((written < 6) || (written < declared)) ? 8'h88 : 8'h80;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rd_sts(output logic [31:0] w);
        logic [7:0] b;
        for (int i = 0; i < 4; i++) begin
            rd(8'(i), b);
            w[8*i +: 8] = b;
        end
    endtask

    task automatic check_sts(input string req, input logic [7:0] flags, input int burst);
        logic [31:0] w;
        rd_sts(w);
        check(req, w, {8'h00, 16'(burst), flags});
    endtask

    task automatic respond(input int n, input int rep_len);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            be_rsp_we = 1'b1; be_rsp_idx = IDXW'(i); be_rsp_byte = rsp[i];
        end
        @(negedge clk);
        be_rsp_we = 1'b0; be_rsp_done = 1'b1; be_rsp_len = 16'(rep_len);
        @(negedge clk);
        be_rsp_done = 1'b0;
    endtask

    task automatic run_txn(input int written, input int declared, input int rlen);
        logic [15:0] crc;
        logic [7:0]  b;
        int          left;
        crc = 16'h0000;
        for (int i = 0; i < written; i++) cmd[i] = 8'($urandom);
        cmd[2] = 8'(declared >> 24); cmd[3] = 8'(declared >> 16);
        cmd[4] = 8'(declared >> 8);  cmd[5] = 8'(declared);
        wr(8'h00, 8'h40);
        check_sts("R3 ready", 8'h40, DEPTH);
        for (int i = 0; i < written; i++) begin
            wr(8'h04, cmd[i]);
            crc = crc_step(crc, cmd[i]);
            check_sts("R4/R5 push", recv_flags(i + 1, declared), DEPTH - i - 1);
        end
        rd(8'h0C, b); check("R10 crc lo", b, crc[7:0]);
        rd(8'h0D, b); check("R10 crc hi", b, crc[15:8]);
        wr(8'h00, 8'h20);
        check_sts("R6 go", 8'h80, 0);
        check("R6 req", be_req, 1'b1);
        check("R6 len", be_cmd_len, 16'(written));
        for (int k = 0; k < written; k += 7) begin
            @(negedge clk); be_cmd_idx = IDXW'(k);
            #1 check("R6 cmd byte", be_cmd_byte, cmd[k]);
        end
        for (int i = 0; i < rlen; i++) rsp[i] = 8'($urandom);
        respond(rlen, rlen);
        check("R7 req drop", be_req, 1'b0);
        check_sts("R7 avail", 8'h90, rlen);
        left = rlen;
        for (int i = 0; i < rlen; i++) begin
            rd(8'h04, b);
            check("R8 data", b, rsp[i]);
            left--;
            check_sts("R8 burst", (left > 0) ? 8'h90 : 8'h80, left);
        end
        rd(8'h04, b);
        check("R8 empty read", b, 8'h00);
        check_sts("R8 after empty", 8'h80, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [31:0] w0, w1;
        logic [15:0] crc;
        void'($urandom(32'h0C0FFEE5));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state and ignored go
        check_sts("R1 reset", 8'h00, DEPTH);
        check("R1 req", be_req, 1'b0);
        wr(8'h00, 8'h20);
        check("R1 go idle", be_req, 1'b0);
        check_sts("R1 after go", 8'h00, DEPTH);

        // R12 unimplemented offsets
        wr(8'h05, 8'h12);
        rd(8'h05, b); check("R12 0x05", b, 8'hFF);
        rd(8'h0E, b); check("R12 0x0E", b, 8'hFF);
        rd(8'h20, b); check("R12 0x20", b, 8'hFF);
        rd(8'hFF, b); check("R12 0xFF", b, 8'hFF);
        check_sts("R12 no effect", 8'h00, DEPTH);

        // R11 interrupt registers
        for (int a = 8'h10; a <= 8'h17; a++) wr(8'(a), 8'hFF);
        for (int a = 8'h10; a <= 8'h17; a++) begin
            rd(8'(a), b); check("R11 irq zero", b, 8'h00);
        end

        // R9 enable register
        wr(8'h08, 8'hFF);
        rd(8'h08, b); check("R9 en byte", b, 8'h01);
        for (int a = 9; a <= 11; a++) begin
            rd(8'(a), b); check("R9 upper zero", b, 8'h00);
        end
        wr(8'h08, 8'h00);
        rd(8'h08, b); check("R9 disable", b, 8'h00);

        // R2 byte 3 write and burst via bytes 1/2
        wr(8'h00, 8'h40);
        rd_sts(w0);
        wr(8'h03, 8'h0F);
        rd_sts(w1);
        check("R2 byte3 write", w1, w0);
        rd(8'h03, b); check("R2 byte3 zero", b, 8'h00);
        rd(8'h01, b); w1[7:0] = b; rd(8'h02, b); w1[15:8] = b;
        check("R2 burst bytes", w1[15:0], 16'(DEPTH));
        wr(8'h01, 8'h00);
        check_sts("R2 byte1 write", 8'h40, DEPTH);

        // R10 directed command, checksum on and off
        wr(8'h08, 8'h01);
        cmd[0]=8'h80; cmd[1]=8'h01; cmd[2]=8'h00; cmd[3]=8'h00; cmd[4]=8'h00; cmd[5]=8'h0C;
        cmd[6]=8'h00; cmd[7]=8'h00; cmd[8]=8'h01; cmd[9]=8'h44; cmd[10]=8'h00; cmd[11]=8'h00;
        wr(8'h00, 8'h40);
        crc = 16'h0000;
        for (int i = 0; i < 12; i++) begin
            wr(8'h04, cmd[i]);
            crc = crc_step(crc, cmd[i]);
            check_sts("R5 directed", (i < 11) ? 8'h88 : 8'h80, DEPTH - i - 1);
        end
        rd(8'h0C, b); check("R10 directed lo", b, crc[7:0]);
        rd(8'h0D, b); check("R10 directed hi", b, crc[15:8]);
        wr(8'h08, 8'h00);
        rd(8'h0C, b); check("R10 disabled lo", b, 8'h00);
        rd(8'h0D, b); check("R10 disabled hi", b, 8'h00);
        wr(8'h08, 8'h01);
        wr(8'h00, 8'h40);
        rd(8'h0C, b); check("R3 crc cleared", b, 8'h00);

        // R4 full buffer, overflow and writes while executing
        for (int i = 0; i < DEPTH; i++) wr(8'h04, (i >= 2 && i <= 5) ? 8'hFF : 8'(i));
        check_sts("R4 full", 8'h88, 0);
        wr(8'h04, 8'h55);
        check_sts("R4 overflow", 8'h88, 0);
        wr(8'h00, 8'h20);
        check("R4 full len", be_cmd_len, 16'(DEPTH));
        wr(8'h04, 8'h66);
        check("R4 exec push ignored", be_cmd_len, 16'(DEPTH));
        @(negedge clk); be_cmd_idx = IDXW'(DEPTH - 1);
        #1 check("R4 last byte kept", be_cmd_byte, 8'(DEPTH - 1));

        // R7 response length clamp, then R3 restart during response
        for (int i = 0; i < DEPTH; i++) rsp[i] = 8'(i ^ 8'hA5);
        respond(DEPTH, 300);
        check_sts("R7 clamp", 8'h90, DEPTH);
        rd(8'h04, b); check("R8 first", b, rsp[0]);
        wr(8'h00, 8'h40);
        check_sts("R3 restart", 8'h40, DEPTH);
        rd(8'h04, b); check("R8 ready read", b, 8'h00);

        // seeded random transactions, plus an early go
        for (int t = 0; t < 20; t++) begin
            run_txn(6 + int'($urandom % 60), 6 + int'($urandom % 60), 1 + int'($urandom % DEPTH));
        end
        run_txn(8, 40, 3);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule